// File: doc/BRIEF.md
# Configurable Endian Byte-Lane Swapper

This block sits between a coprocessor's internal datapath and an external data bus that is either 32 or 16 bits wide. For every transfer it reorders byte lanes according to the configured byte ordering and to the kind of entity being moved. The entity kinds are raw frame bytes, 16-bit words, 32-bit address pointers, and split doublewords (statistics counters and the control block absolute address), which are always handled as two independent 16-bit halves.

Big-endian operation comes in two flavours. The legacy flavour swaps bytes only within 16-bit units and has no true doubleword support. The enhanced flavour reverses a pointer as one 32-bit value. It is selected by bit 7 of the system-bus configuration byte and takes effect only in flat linear addressing. Word and doubleword entities at a misaligned address raise an alignment flag and pass through untouched. The swap logic is combinational and feeds a registered output stage, so the latency is one clock.

Top module: `endian_lane_swapper`

## Requirements
- R1: While `rstN` is low, and after its release until the first valid transfer, `outData` is 0, `outValid` is 0 and `alignErr` is 0.
- R2: A transfer presented with `inValid` high appears on `outData`/`alignErr` one clock later with `outValid` high. When `inValid` is low, `outValid` is low on the next clock and `outData` holds its previous value.
- R3: With `bigEndian` low, `outData` equals `inData` for every entity kind and bus width.
- R4: Kind 0 (raw frame bytes) is never reordered on a 32-bit bus, and it raises no alignment error at any address.
- R5: With `bigEndian` high on a 32-bit bus, kind 1 (word) swaps the two bytes within each 16-bit half: result is {d[23:16], d[31:24], d[7:0], d[15:8]}.
- R6: Kind 2 (pointer) is fully byte-reversed to {d[7:0], d[15:8], d[23:16], d[31:24]} when `bigEndian`, `linearMode` and `sysCfg[7]` are all high on a 32-bit bus.
- R7: Kind 2 with `sysCfg[7]` low or `linearMode` low (legacy big-endian) is swapped as two 16-bit halves, as in R5.
- R8: Kind 3 (split doubleword) is always swapped as two 16-bit halves in big-endian mode, whatever the value of `sysCfg[7]`.
- R9: With `bigEndian` high and `bus16` high, `outData[31:16]` is 0. For kinds 1 to 3 the low half is {d[7:0], d[15:8]}; for kind 0 it is d[15:0].
- R10: Kind 1 with `addrLow[0]` = 1, or kind 2 or 3 with `addrLow` not equal to 0, sets `alignErr` and passes `inData` through unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Transfer present this cycle |
| inData | input | 32 | Data word in internal lane order |
| entityKind | input | 2 | 0 raw bytes, 1 word, 2 pointer, 3 split doubleword |
| addrLow | input | 2 | Low address bits of the entity |
| bigEndian | input | 1 | Big-endian memory organisation |
| bus16 | input | 1 | External bus is 16 bits wide |
| linearMode | input | 1 | Flat linear addressing is active |
| sysCfg | input | 8 | System-bus configuration byte; bit 7 enables enhanced big-endian |
| outData | output | 32 | Registered lane-swapped word |
| outValid | output | 1 | `outData` holds a new result |
| alignErr | output | 1 | Registered misalignment flag |

## Verification
Every result (`outData`, `outValid` and `alignErr`) is due exactly one clock after the edge that samples a valid transfer. The bench changes inputs on the falling edge, lets one rising edge capture them, and reads the outputs on the next falling edge, away from any active edge. For the hold behaviour, it drives new data with `inValid` low, lets two rising edges pass, and then checks that `outData` is unchanged and `outValid` is low.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;
  typedef enum logic [1:0] {
    KIND_RAW   = 2'd0,
    KIND_HALF  = 2'd1,
    KIND_PTR   = 2'd2,
    KIND_SPLIT = 2'd3
  } entity_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic passThru;
    logic halfSwap;
    logic fullRev;
    logic narrowBus;
    logic alignErr;
  } swap_strobe_t;

  localparam int CFG_ENH_BIT = 7;
endpackage

// File: rtl/lane_swap_ctrl.sv
module lane_swap_ctrl
  import lane_swap_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       entityKind,
  input  logic [1:0]       addrLow,
  input  logic             bigEndian,
  input  logic             bus16,
  input  logic             linearMode,
  input  logic [CFG_W-1:0] sysCfg,
  output swap_strobe_t     strb
);
  entity_kind_e kind;
  logic misaligned;
  logic enhActive;

  assign kind      = entity_kind_e'(entityKind);
  assign enhActive = linearMode && sysCfg[CFG_ENH_BIT];

  always_comb begin
    unique case (kind)
      KIND_HALF:             misaligned = addrLow[0];
      KIND_PTR, KIND_SPLIT:  misaligned = (addrLow != 2'b00);
      default:               misaligned = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (misaligned) begin
      strb.alignErr = 1'b1;
      strb.passThru = 1'b1;
    end else if (!bigEndian) begin
      strb.passThru = 1'b1;
    end else if (bus16) begin
      strb.narrowBus = 1'b1;
      strb.halfSwap  = (kind != KIND_RAW);
    end else begin
      unique case (kind)
        KIND_RAW:   strb.passThru = 1'b1;
        KIND_PTR:   begin
          strb.fullRev  = enhActive;
          strb.halfSwap = !enhActive;
        end
        default:    strb.halfSwap = 1'b1;
      endcase
    end
  end

  AST_LE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!bigEndian) |-> strb.passThru);  // R3
  AST_ENH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.fullRev |-> (linearMode && sysCfg[CFG_ENH_BIT] && entityKind == 2'd2));  // R6
  AST_SPLIT_NO_REV: assert property (@(posedge clk) disable iff (!rstN)
    (entityKind == 2'd3) |-> !strb.fullRev);  // R8
  AST_ERR_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strb.alignErr |-> (strb.passThru && !strb.narrowBus && !strb.halfSwap));  // R10
endmodule

// File: rtl/lane_swap_datapath.sv
module lane_swap_datapath
  import lane_swap_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [LANES*LANE_W-1:0] inData,
  input  swap_strobe_t            strb,
  output logic [LANES*LANE_W-1:0] outData,
  output logic                    outValid,
  output logic                    alignFlag
);
  localparam int DW = LANES * LANE_W;
  localparam int HW = DW / 2;
  localparam int HALF_LANES = LANES / 2;

  logic [DW-1:0] revWord;
  logic [DW-1:0] halfWord;
  logic [DW-1:0] nextData;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int H = i / HALF_LANES;
    localparam int J = i % HALF_LANES;
    assign revWord[i*LANE_W +: LANE_W]  = inData[(LANES-1-i)*LANE_W +: LANE_W];
    assign halfWord[i*LANE_W +: LANE_W] =
      inData[(H*HALF_LANES + HALF_LANES-1-J)*LANE_W +: LANE_W];
  end

  always_comb begin
    if (strb.passThru)       nextData = inData;
    else if (strb.narrowBus) nextData = {{HW{1'b0}},
                                         strb.halfSwap ? halfWord[HW-1:0] : inData[HW-1:0]};
    else if (strb.fullRev)   nextData = revWord;
    else if (strb.halfSwap)  nextData = halfWord;
    else                     nextData = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outValid  <= 1'b0;
      alignFlag <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outData   <= nextData;
        alignFlag <= strb.alignErr;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outData)));  // R2
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.narrowBus) |=> (outData[DW-1:HW] == '0));  // R9
  AST_MISALIGN_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.alignErr) |=> (alignFlag && outData == $past(inData)));  // R10
endmodule

// File: rtl/endian_lane_swapper.sv
module endian_lane_swapper
  import lane_swap_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LANE_W = 8,
  parameter int CFG_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [LANES*LANE_W-1:0] inData,
  input  logic [1:0]              entityKind,
  input  logic [1:0]              addrLow,
  input  logic                    bigEndian,
  input  logic                    bus16,
  input  logic                    linearMode,
  input  logic [CFG_W-1:0]        sysCfg,
  output logic [LANES*LANE_W-1:0] outData,
  output logic                    outValid,
  output logic                    alignErr
);
  swap_strobe_t strb;

  lane_swap_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .entityKind(entityKind), .addrLow(addrLow),
    .bigEndian(bigEndian), .bus16(bus16), .linearMode(linearMode),
    .sysCfg(sysCfg), .strb(strb)
  );

  lane_swap_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .strb(strb), .outData(outData), .outValid(outValid), .alignFlag(alignErr)
  );
endmodule

// File: tb/endian_lane_swapper_bench.sv
`timescale 1ns/1ps
module endian_lane_swapper_bench;
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  addr;
    logic        be;
    logic        b16;
    logic        lin;
    logic [7:0]  cfg;
    logic [31:0] din;
    logic [31:0] dexp;
    logic        eexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 8'h80, 32'h11223344, 32'h11223344, 1'b0, 8'd3},   // R3
    '{2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'h80, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b0, 8'd3},   // R3
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h80, 32'h11223344, 32'h11223344, 1'b0, 8'd4},   // R4
    '{2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 8'h80, 32'h11223344, 32'h22114433, 1'b0, 8'd5},   // R5
    '{2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 8'h80, 32'h11223344, 32'h22114433, 1'b0, 8'd8},   // R8
    '{2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 8'h80, 32'hA1B2C3D4, 32'hD4C3B2A1, 1'b0, 8'd6},   // R6
    '{2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 8'h7F, 32'hA1B2C3D4, 32'hB2A1D4C3, 1'b0, 8'd7},   // R7
    '{2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 8'h80, 32'h11223344, 32'h22114433, 1'b0, 8'd7},   // R7
    '{2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 8'h80, 32'h11223344, 32'h00004433, 1'b0, 8'd9},   // R9
    '{2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 8'h80, 32'h11223344, 32'h00003344, 1'b0, 8'd9},   // R9
    '{2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 8'h80, 32'h11223344, 32'h11223344, 1'b1, 8'd10},  // R10
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 8'h80, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b1, 8'd10},  // R10
    '{2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 8'h80, 32'h55667788, 32'h55667788, 1'b0, 8'd4},   // R4
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 8'h80, 32'h55667788, 32'h66558877, 1'b0, 8'd5},   // R5
    '{2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 8'h80, 32'h55667788, 32'h55667788, 1'b1, 8'd10},  // R10
    '{2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 8'h80, 32'hA1B2C3D4, 32'h0000D4C3, 1'b0, 8'd9}    // R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0] entityKind = '0;
  logic [1:0] addrLow = '0;
  logic bigEndian = 1'b0;
  logic bus16 = 1'b0;
  logic linearMode = 1'b0;
  logic [7:0] sysCfg = '0;
  logic [31:0] outData;
  logic outValid;
  logic alignErr;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  endian_lane_swapper u_endian_lane_swapper (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .entityKind(entityKind), .addrLow(addrLow), .bigEndian(bigEndian),
    .bus16(bus16), .linearMode(linearMode), .sysCfg(sysCfg),
    .outData(outData), .outValid(outValid), .alignErr(alignErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 outData in reset", outData, 32'h0);
    check("R1 outValid in reset", {31'h0, outValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outData after release", outData, 32'h0);
    check("R1 alignErr after release", {31'h0, alignErr}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      inValid    = 1'b1;
      entityKind = VECS[i].kind;
      addrLow    = VECS[i].addr;
      bigEndian  = VECS[i].be;
      bus16      = VECS[i].b16;
      linearMode = VECS[i].lin;
      sysCfg     = VECS[i].cfg;
      inData     = VECS[i].din;
      @(negedge clk);
      check($sformatf("R%0d vec %0d data", VECS[i].req, i), outData, VECS[i].dexp);
      check($sformatf("R%0d vec %0d alignErr", VECS[i].req, i), {31'h0, alignErr}, {31'h0, VECS[i].eexp});
      check($sformatf("R2 vec %0d outValid", i), {31'h0, outValid}, 32'h1);
      inValid = 1'b0;
    end

    // R2: idle cycles hold the data and drop valid
    @(negedge clk);
    inValid = 1'b1; entityKind = 2'd2; addrLow = 2'd0; bigEndian = 1'b1;
    bus16 = 1'b0; linearMode = 1'b1; sysCfg = 8'h80; inData = 32'hCAFE0123;
    @(negedge clk);
    check("R6 directed reverse", outData, 32'h2301FECA);
    inValid = 1'b0; inData = 32'hDEADBEEF;
    repeat (2) @(negedge clk);
    check("R2 hold outData", outData, 32'h2301FECA);
    check("R2 outValid low when idle", {31'h0, outValid}, 32'h0);

    // R3: little-endian on 16-bit bus, misalignment-free split
    inValid = 1'b1; entityKind = 2'd3; bigEndian = 1'b0; bus16 = 1'b1; inData = 32'h0BADF00D;
    @(negedge clk);
    check("R3 little-endian narrow passthrough", outData, 32'h0BADF00D);
    inValid = 1'b0;

    // R8: split doubleword with enhanced bit toggled either way
    @(negedge clk);
    inValid = 1'b1; entityKind = 2'd3; bigEndian = 1'b1; bus16 = 1'b0; sysCfg = 8'h00;
    inData = 32'hA1B2C3D4;
    @(negedge clk);
    check("R8 split with enhanced clear", outData, 32'hB2A1D4C3);
    inValid = 1'b0;

    // R10: misaligned word in little-endian still flags
    @(negedge clk);
    inValid = 1'b1; entityKind = 2'd1; addrLow = 2'd3; bigEndian = 1'b0; inData = 32'h12345678;
    @(negedge clk);
    check("R10 little-endian misaligned flag", {31'h0, alignErr}, 32'h1);
    check("R10 little-endian misaligned data", outData, 32'h12345678);
    inValid = 1'b0;

    // R1: reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset outData", outData, 32'h0);
    check("R1 re-reset alignErr", {31'h0, alignErr}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule